// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised register, eight bits wide by default, that does one of four things on each rising clock edge: keep its value, shift toward the high end, shift toward the low end, or capture a parallel word. A two-bit mode input selects the operation. The parallel input and the register's contents use one shared bidirectional bus. For synthesis that bus is split into an input vector, an output vector and a single drive-enable. The parent ties these to its pad or tri-state logic.

Two active-low enables must both be low before the block drives the bus. The block also stops driving the bus while the mode is parallel capture, so that an external source can drive the bus without contention. The lowest and highest register bits always appear on two dedicated serial outputs. Two instances can therefore be chained into a wider shifter: the low instance's top bit feeds the high instance's low serial input, and the high instance's bottom bit feeds the low instance's high serial input. An asynchronous active-low reset clears the register.

Top module: `univ_shift_bank`

## Requirements
- R1: With mode 2'b00 (keep), a rising clock edge leaves the register value unchanged.
- R2: With mode 2'b11 (capture), a rising clock edge writes bus_in[n] into register bit n for every n.
- R3: With mode 2'b01 (shift up), a rising clock edge moves bit n to bit n+1 and places ser_in_lo in bit 0.
- R4: With mode 2'b10 (shift down), a rising clock edge moves bit n to bit n-1 and places ser_in_hi in bit WIDTH-1.
- R5: While rst_n is low, every register bit is zero. Clearing happens at once, without a clock edge, whatever the mode and data inputs.
- R6: After rst_n goes high, the first rising clock edge performs the selected mode normally.
- R7: bus_drive is 1 exactly when oe_a_n and oe_b_n are both 0 and the mode is not 2'b11.
- R8: bus_out always shows the register contents, whatever the state of the enables.
- R9: tail_lo always equals register bit 0 and tail_hi always equals bit WIDTH-1, whatever the state of the enables.
- R10: Two instances chained through their serial pins act as one register of twice the width, in both shift directions.
- R11: Input changes between rising edges do not change the register. Only the values present at the edge take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 keep, 01 shift up, 10 shift down, 11 capture |
| ser_in_lo | input | 1 | Serial bit that enters bit 0 on a shift up |
| ser_in_hi | input | 1 | Serial bit that enters bit WIDTH-1 on a shift down |
| oe_a_n | input | 1 | First bus enable, active low |
| oe_b_n | input | 1 | Second bus enable, active low |
| bus_in | input | WIDTH | Value sampled from the shared bus |
| bus_out | output | WIDTH | Register contents offered to the shared bus |
| bus_drive | output | 1 | High when the block should drive the shared bus |
| tail_lo | output | 1 | Register bit 0 |
| tail_hi | output | 1 | Register bit WIDTH-1 |

## Verification
The clocked properties assume that mode, the serial inputs and bus_in are stable around each rising edge. They also assume that rst_n is released away from an edge, so that the value seen at the edge is the value captured. The bench changes inputs only on falling edges, with one exception: it pulses extra values mid-cycle. It still leaves the final value in place before the next rising edge. Reset is asserted and released on falling edges or midway through the low phase. The chain of two instances uses the same timing, so the serial bit passed between instances has settled well before the edge that consumes it.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;
   typedef enum logic [1:0] {
      MODE_KEEP  = 2'b00,
      MODE_UP    = 2'b01,
      MODE_DOWN  = 2'b10,
      MODE_LOAD  = 2'b11
   } usr_mode_e;

   function automatic logic usr_is_load(input usr_mode_e m);
      return m == MODE_LOAD;
   endfunction
endpackage

// File: rtl/usr_next_state.sv
`timescale 1ns/1ps
// Per-bit selection of the value captured at the next edge (R1..R4).
module usr_next_state #(
   parameter int WIDTH = 8
) (
   input  usr_pkg::usr_mode_e mode,
   input  logic [WIDTH-1:0]   cur_q,
   input  logic [WIDTH-1:0]   par_in,
   input  logic               ser_lo,
   input  logic               ser_hi,
   output logic [WIDTH-1:0]   nxt_q
);
   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_below;
      logic from_above;
      if (i == 0) begin : g_lo_edge
         assign from_below = ser_lo;
      end else begin : g_lo_mid
         assign from_below = cur_q[i-1];
      end
      if (i == TOP) begin : g_hi_edge
         assign from_above = ser_hi;
      end else begin : g_hi_mid
         assign from_above = cur_q[i+1];
      end

      always_comb begin
         unique case (mode)
            usr_pkg::MODE_UP:   nxt_q[i] = from_below;
            usr_pkg::MODE_DOWN: nxt_q[i] = from_above;
            usr_pkg::MODE_LOAD: nxt_q[i] = par_in[i];
            default:            nxt_q[i] = cur_q[i];
         endcase
      end
   end
endmodule

// File: rtl/usr_state_reg.sv
`timescale 1ns/1ps
// Storage with asynchronous clear (R5, R6).
module usr_state_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end
endmodule

// File: rtl/usr_bus_ctrl.sv
`timescale 1ns/1ps
// Bus drive qualification (R7). The variant picks whether capture mode frees the bus.
module usr_bus_ctrl #(
   parameter bit LOAD_FREES_BUS = 1'b1
) (
   input  usr_pkg::usr_mode_e mode,
   input  logic               oe_a_n,
   input  logic               oe_b_n,
   output logic               drive
);
   logic both_on;
   assign both_on = ~(oe_a_n | oe_b_n);

   if (LOAD_FREES_BUS) begin : g_release_on_load
      assign drive = both_on & ~usr_pkg::usr_is_load(mode);
   end else begin : g_enables_only
      assign drive = both_on;
   end
endmodule

// File: rtl/univ_shift_bank.sv
`timescale 1ns/1ps
module univ_shift_bank #(
   parameter int WIDTH          = 8,
   parameter bit LOAD_FREES_BUS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             ser_in_lo,
   input  logic             ser_in_hi,
   input  logic             oe_a_n,
   input  logic             oe_b_n,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_drive,
   output logic             tail_lo,
   output logic             tail_hi
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("univ_shift_bank: WIDTH must be at least 2");
   end

   usr_pkg::usr_mode_e mode_e;
   logic [WIDTH-1:0]   state_q;
   logic [WIDTH-1:0]   state_d;

   assign mode_e = usr_pkg::usr_mode_e'(mode);

   usr_next_state #(.WIDTH(WIDTH)) u_next (
      .mode   (mode_e),
      .cur_q  (state_q),
      .par_in (bus_in),
      .ser_lo (ser_in_lo),
      .ser_hi (ser_in_hi),
      .nxt_q  (state_d)
   );

   usr_state_reg #(.WIDTH(WIDTH)) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (state_d),
      .q     (state_q)
   );

   usr_bus_ctrl #(.LOAD_FREES_BUS(LOAD_FREES_BUS)) u_bus (
      .mode   (mode_e),
      .oe_a_n (oe_a_n),
      .oe_b_n (oe_b_n),
      .drive  (bus_drive)
   );

   // R8, R9: contents and end bits are visible regardless of the enables.
   assign bus_out = state_q;
   assign tail_lo = state_q[0];
   assign tail_hi = state_q[TOP];
endmodule

// File: rtl/usr_checker.sv
`timescale 1ns/1ps
module usr_checker #(
   parameter int WIDTH          = 8,
   parameter bit LOAD_FREES_BUS = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             ser_in_lo,
   input logic             ser_in_hi,
   input logic             oe_a_n,
   input logic             oe_b_n,
   input logic [WIDTH-1:0] bus_in,
   input logic [WIDTH-1:0] bus_out,
   input logic             bus_drive,
   input logic             tail_lo,
   input logic             tail_hi
);
   assert_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> $stable(bus_out));

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |=> (bus_out == $past(bus_in)));

   assert_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=> (bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_in_lo)}));

   assert_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |=> (bus_out == {$past(ser_in_hi), $past(bus_out[WIDTH-1:1])}));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_clear_R5: assert (bus_out == '0);
      end
   end

   assert_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> (!oe_a_n && !oe_b_n));

   if (LOAD_FREES_BUS) begin : g_load_chk
      assert_load_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'b11) |-> !bus_drive);
   end

   assert_tails_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_lo == bus_out[0]) && (tail_hi == bus_out[WIDTH-1]));
endmodule

bind univ_shift_bank usr_checker #(.WIDTH(WIDTH), .LOAD_FREES_BUS(LOAD_FREES_BUS)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .ser_in_lo(ser_in_lo), .ser_in_hi(ser_in_hi),
   .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bus_in), .bus_out(bus_out),
   .bus_drive(bus_drive), .tail_lo(tail_lo), .tail_hi(tail_hi)
);

// File: tb/univ_shift_bank_tb.sv
`timescale 1ns/1ps
module univ_shift_bank_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       ser_r = 1'b0, ser_l = 1'b0;
   logic       oe_a_n = 1'b1, oe_b_n = 1'b1;
   logic [7:0] in_lo = '0, in_hi = '0;
   logic [7:0] out_lo, out_hi;
   logic       drv_lo, drv_hi, tlo_lo, thi_lo, tlo_hi, thi_hi;

   // u_dut holds bits 7..0 of the chained value, u_hi holds bits 15..8 (R10)
   univ_shift_bank u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .ser_in_lo(ser_r), .ser_in_hi(tlo_hi),
      .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(in_lo), .bus_out(out_lo),
      .bus_drive(drv_lo), .tail_lo(tlo_lo), .tail_hi(thi_lo)
   );
   univ_shift_bank u_hi (
      .clk(clk), .rst_n(rst_n), .mode(mode), .ser_in_lo(thi_lo), .ser_in_hi(ser_l),
      .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(in_hi), .bus_out(out_hi),
      .bus_drive(drv_hi), .tail_lo(tlo_hi), .tail_hi(thi_hi)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    running  = 1'b0;
   bit    finished = 1'b0;
   bit    fresh    = 1'b0;
   string last_tag = "R5";
   logic [15:0] model = '0;

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   // Behavioural reference of the 16-bit chain
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model = '0;
         last_tag = "R5";
         fresh = 1'b1;
      end else begin
         case (mode)
            2'b11: begin model = {in_hi, in_lo};        last_tag = "R2"; end
            2'b01: begin model = {model[14:0], ser_r};  last_tag = "R3 R10"; end
            2'b10: begin model = {ser_l, model[15:1]};  last_tag = "R4 R10"; end
            default: last_tag = "R1";
         endcase
         if (fresh) last_tag = {"R6 ", last_tag};
         fresh = 1'b0;
      end
   end

   // Compare on every cycle, 1 ns after the falling edge
   always begin
      @(negedge clk);
      #1;
      if (running) begin
         bit exp_drv;
         exp_drv = !oe_a_n && !oe_b_n && (mode != 2'b11);
         check({out_hi, out_lo} == model, {last_tag, " R8"}, {out_hi, out_lo}, model);
         check({thi_hi, tlo_hi, thi_lo, tlo_lo} == {model[15], model[8], model[7], model[0]},
               "R9", {12'd0, thi_hi, tlo_hi, thi_lo, tlo_lo},
               {12'd0, model[15], model[8], model[7], model[0]});
         check({drv_hi, drv_lo} == {exp_drv, exp_drv}, "R7",
               {14'd0, drv_hi, drv_lo}, {14'd0, exp_drv, exp_drv});
      end
   end

   task automatic drive(input logic [1:0] m, input logic sr, input logic sl,
                        input logic a, input logic b, input logic [15:0] d);
      @(negedge clk);
      mode = m; ser_r = sr; ser_l = sl; oe_a_n = a; oe_b_n = b;
      {in_hi, in_lo} = d;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      running = 1'b1;
      // R5: reset dominates a capture request
      repeat (3) drive(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF);
      // R6: first edge after release captures
      drive(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5AC3);
      rst_n = 1'b1;
      // R1, R7, R8: keep under every enable pair with noisy bus data
      for (int k = 0; k < 4; k++) drive(2'b00, 1'b1, 1'b1, k[0], k[1], 16'h1234 * (k + 1));
      drive(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001);
      drive(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
      // R3, R10: sixteen shifts up through the chain
      for (int k = 0; k < 16; k++) drive(2'b01, 16'hB4E1 >> k, 1'b0, 1'b0, 1'b0, 16'h0F0F);
      // R4, R10: sixteen shifts down through the chain
      for (int k = 0; k < 16; k++) drive(2'b10, 1'b0, 16'h2D97 >> k, 1'b0, 1'b1, 16'hF0F0);
      // R11: mid-cycle input changes, only the value at the edge counts
      drive(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hAAAA);
      #1.5;
      {in_hi, in_lo} = 16'h3C69;
      #0.2;
      check({out_hi, out_lo} == model, "R11", {out_hi, out_lo}, model);
      // R5: asynchronous clear in the middle of the low phase
      drive(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000);
      #1.5;
      rst_n = 1'b0;
      #0.3;
      check({out_hi, out_lo} == 16'h0000, "R5", {out_hi, out_lo}, 16'h0000);
      drive(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC0DE);
      rst_n = 1'b1;
      // Mixed traffic
      for (int k = 0; k < 300; k++) begin
         logic [31:0] r;
         r = $urandom;
         drive(r[1:0], r[2], r[3], r[4], r[5], r[31:16]);
      end
      drive(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
      @(negedge clk);
      #2;
      finished = 1'b1;
      summary();
   end
endmodule